// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus whose data line is held low by a target that lost its place in the middle of a transfer. It is started with a one-cycle request and works in one of two ways. In line mode it disables the normal byte controller and takes the SCL pin itself. It releases SCL for one half period first. At the end of every released phase it samples both lines. It then drives SCL low for a half period and releases it again, for at most nine low pulses. It stops early as soon as SDA is seen high. SDA is only sensed and never driven. In byte mode it is meant for controllers that have no direct line control. It asks the byte engine to shift an all-ones byte framed by a START and a STOP, with the acknowledge bit forced to NACK, so that the target sees nine clocks with SDA high.

The top-level state machine has four states. `T_IDLE` goes to `T_LINE` or `T_BYTE` on an accepted start. Either of those goes to `T_REPORT` when its walker finishes, and `T_REPORT` returns to `T_IDLE` after one cycle. The line walker has three states. `LW_IDLE` goes to `LW_RELEASE` on go. When a half period ends, `LW_RELEASE` either goes to `LW_PULL` or finishes back to `LW_IDLE`. `LW_PULL` goes to `LW_RELEASE` when its half period ends. The byte walker steps through six states in order: `BW_IDLE`, `BW_LOAD`, `BW_START`, `BW_WAIT_START`, `BW_STOP`, `BW_WAIT_STOP`. It leaves each wait state on the engine's completion pulse and returns to `BW_IDLE` after the second one.

The half period is `CLK_FREQ_HZ / (2 * SCL_FREQ_HZ)` system cycles. The defaults are a 250 MHz clock and a 100 kHz recovery clock, which gives 1250 cycles.

Top module: `i2c_bus_recovery`

## Requirements
- R1: After reset, busy_o, done_o and scl_oe_o are 0, err_o is 0 and eng_en_o is 1.
- R2: In line mode (byte_mode_i = 0 at the accepted start), eng_en_o is 0 from the cycle after the start until the report cycle. SCL stays released for exactly one half period before the first line check.
- R3: In line mode, every SCL low phase and every released phase that ends in a new low phase lasts exactly HALF_CYCLES clocks.
- R4: If SDA reads high at the end of a released phase, no further low pulse is issued and err_o = 0 (success).
- R5: At most MAX_PULSES (9) low pulses are issued. If SDA is still low after the last one, err_o = 2 (SDA stuck).
- R6: If SCL reads low at the end of a released phase (before the final one), the run ends with err_o = 1 (SCL stuck) and no further pulse. This check takes priority over the SDA check.
- R7: eng_en_o is 1 again from the report cycle onward.
- R8: In byte mode, the block pulses eng_load_o once with eng_data_o = 0xFF. Then it pulses eng_start_o with eng_nack_o = 1 and waits for eng_done_i. Then it pulses eng_stop_o and waits for eng_done_i again, and ends with err_o = 0 without ever driving SCL.
- R9: busy_o stays high from the cycle after the start up to and including the report cycle. done_o is high for exactly one cycle, the report cycle.
- R10: err_o is cleared when a start is accepted and then holds its value until the next accepted start.
- R11: A start request while busy_o is high, including in the report cycle, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted only while idle |
| byte_mode_i | input | 1 | Mode sampled at start: 0 line mode, 1 byte mode |
| busy_o | output | 1 | Recovery in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 2 | Result: 0 success, 1 SCL stuck, 2 SDA stuck |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_oe_o | output | 1 | Pull SCL low when 1 (open drain) |
| eng_en_o | output | 1 | Enable for the normal byte controller |
| eng_load_o | output | 1 | Strobe: load eng_data_o into the byte engine |
| eng_data_o | output | 8 | Byte to load |
| eng_start_o | output | 1 | Strobe: START plus byte transfer |
| eng_nack_o | output | 1 | Force NACK in the acknowledge slot, valid with eng_start_o |
| eng_stop_o | output | 1 | Strobe: STOP condition |
| eng_done_i | input | 1 | Byte engine completion pulse |

## Verification
Some rules hold on every cycle, and the assertions watch those. done_o is a single-cycle pulse and busy_o holds until it. err_o does not move between runs. The controller is disabled only inside a run. No SCL low phase is longer than a half period, and no run issues more than nine low pulses. The engine strobes are mutually exclusive and occur only in byte mode. Other behaviour can only be shown by the bench's scenarios, which play a target holding SDA for a chosen number of pulses and a line jammed after a chosen number of releases. These scenarios show the exact half-period widths, the early exit, the pulse count at which each run ends, the priority of the SCL check over the SDA check, and the ordered handshake with the byte engine.

// File: rtl/i2c_rcv_pkg.sv
package i2c_rcv_pkg;

    typedef enum logic [1:0] {
        RCV_OK        = 2'd0,
        RCV_SCL_STUCK = 2'd1,
        RCV_SDA_STUCK = 2'd2
    } rcv_code_e;

    typedef enum logic [1:0] {
        T_IDLE,
        T_LINE,
        T_BYTE,
        T_REPORT
    } top_state_e;

    typedef enum logic [1:0] {
        LW_IDLE,
        LW_RELEASE,
        LW_PULL
    } line_state_e;

    typedef enum logic [2:0] {
        BW_IDLE,
        BW_LOAD,
        BW_START,
        BW_WAIT_START,
        BW_STOP,
        BW_WAIT_STOP
    } byte_state_e;

endpackage

// File: rtl/i2c_rcv_halftimer.sv
module i2c_rcv_halftimer #(
    parameter int unsigned HALF_CYCLES = 1250,
    localparam int unsigned CW = $clog2(HALF_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);

    logic [CW-1:0] cnt_q;
    logic          at_end;

    assign at_end = (cnt_q == CW'(HALF_CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || at_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = run_i && at_end;

endmodule

// File: rtl/i2c_rcv_linewalk.sv
module i2c_rcv_linewalk
    import i2c_rcv_pkg::*;
#(
    parameter int unsigned HALF_CYCLES = 1250,
    parameter int unsigned MAX_PULSES  = 9,
    localparam int unsigned PW = $clog2(MAX_PULSES + 1)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      go_i,
    input  logic      scl_i,
    input  logic      sda_i,
    output logic      scl_oe_o,
    output logic      fin_o,
    output rcv_code_e code_o
);

    line_state_e state_q, state_d;
    logic [PW-1:0] pulses_q;
    logic          tick;
    logic          last_done;

    i2c_rcv_halftimer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state_q != LW_IDLE),
        .tick_o (tick)
    );

    assign last_done = (pulses_q == PW'(MAX_PULSES));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= LW_IDLE;
            pulses_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == LW_IDLE) begin
                pulses_q <= '0;
            end else if (state_q == LW_PULL && tick) begin
                pulses_q <= pulses_q + 1'b1;
            end
        end
    end

    // next state and result
    always_comb begin
        state_d = state_q;
        fin_o   = 1'b0;
        code_o  = RCV_OK;
        unique case (state_q)
            LW_IDLE: begin
                if (go_i) state_d = LW_RELEASE;
            end
            LW_RELEASE: begin
                if (tick) begin
                    if (last_done) begin
                        fin_o   = 1'b1;
                        code_o  = sda_i ? RCV_OK : RCV_SDA_STUCK;
                        state_d = LW_IDLE;
                    end else if (!scl_i) begin
                        fin_o   = 1'b1;
                        code_o  = RCV_SCL_STUCK;
                        state_d = LW_IDLE;
                    end else if (sda_i) begin
                        fin_o   = 1'b1;
                        code_o  = RCV_OK;
                        state_d = LW_IDLE;
                    end else begin
                        state_d = LW_PULL;
                    end
                end
            end
            LW_PULL: begin
                if (tick) state_d = LW_RELEASE;
            end
            default: state_d = LW_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        scl_oe_o = (state_q == LW_PULL);
    end

endmodule

// File: rtl/i2c_rcv_bytewalk.sv
module i2c_rcv_bytewalk
    import i2c_rcv_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic              eng_done_i,
    output logic              eng_load_o,
    output logic [DATA_W-1:0] eng_data_o,
    output logic              eng_start_o,
    output logic              eng_nack_o,
    output logic              eng_stop_o,
    output logic              fin_o
);

    byte_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BW_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BW_IDLE:       if (go_i) state_d = BW_LOAD;
            BW_LOAD:       state_d = BW_START;
            BW_START:      state_d = BW_WAIT_START;
            BW_WAIT_START: if (eng_done_i) state_d = BW_STOP;
            BW_STOP:       state_d = BW_WAIT_STOP;
            BW_WAIT_STOP:  if (eng_done_i) state_d = BW_IDLE;
            default:       state_d = BW_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        eng_load_o  = (state_q == BW_LOAD);
        eng_data_o  = (state_q == BW_LOAD) ? {DATA_W{1'b1}} : '0;
        eng_start_o = (state_q == BW_START);
        eng_nack_o  = (state_q == BW_START);
        eng_stop_o  = (state_q == BW_STOP);
        fin_o       = (state_q == BW_WAIT_STOP) && eng_done_i;
    end

endmodule

// File: rtl/i2c_bus_recovery.sv
module i2c_bus_recovery
    import i2c_rcv_pkg::*;
#(
    parameter int unsigned CLK_FREQ_HZ = 250_000_000,
    parameter int unsigned SCL_FREQ_HZ = 100_000,
    parameter int unsigned MAX_PULSES  = 9,
    localparam int unsigned HALF_CYCLES = CLK_FREQ_HZ / (2 * SCL_FREQ_HZ)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       byte_mode_i,
    output logic       busy_o,
    output logic       done_o,
    output logic [1:0] err_o,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe_o,
    output logic       eng_en_o,
    output logic       eng_load_o,
    output logic [7:0] eng_data_o,
    output logic       eng_start_o,
    output logic       eng_nack_o,
    output logic       eng_stop_o,
    input  logic       eng_done_i
);

    top_state_e state_q, state_d;
    rcv_code_e  err_q;
    logic       accept;
    logic       line_go, byte_go;
    logic       line_fin, byte_fin;
    rcv_code_e  line_code;

    assign accept  = (state_q == T_IDLE) && start_i;
    assign line_go = accept && !byte_mode_i;
    assign byte_go = accept && byte_mode_i;

    i2c_rcv_linewalk #(
        .HALF_CYCLES (HALF_CYCLES),
        .MAX_PULSES  (MAX_PULSES)
    ) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (line_go),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_oe_o (scl_oe_o),
        .fin_o    (line_fin),
        .code_o   (line_code)
    );

    i2c_rcv_bytewalk #(.DATA_W(8)) u_byte (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_i        (byte_go),
        .eng_done_i  (eng_done_i),
        .eng_load_o  (eng_load_o),
        .eng_data_o  (eng_data_o),
        .eng_start_o (eng_start_o),
        .eng_nack_o  (eng_nack_o),
        .eng_stop_o  (eng_stop_o),
        .fin_o       (byte_fin)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= T_IDLE;
            err_q   <= RCV_OK;
        end else begin
            state_q <= state_d;
            if (accept) begin
                err_q <= RCV_OK;
            end else if (state_q == T_LINE && line_fin) begin
                err_q <= line_code;
            end else if (state_q == T_BYTE && byte_fin) begin
                err_q <= RCV_OK;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            T_IDLE:   if (start_i) state_d = byte_mode_i ? T_BYTE : T_LINE;
            T_LINE:   if (line_fin) state_d = T_REPORT;
            T_BYTE:   if (byte_fin) state_d = T_REPORT;
            T_REPORT: state_d = T_IDLE;
            default:  state_d = T_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy_o   = (state_q != T_IDLE);
        done_o   = (state_q == T_REPORT);
        eng_en_o = (state_q != T_LINE);
        err_o    = err_q;
    end

endmodule

// File: rtl/i2c_bus_recovery_chk.sv
module i2c_bus_recovery_chk #(
    parameter int unsigned HALF_CYCLES = 1250,
    parameter int unsigned MAX_PULSES  = 9
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       busy_o,
    input logic       done_o,
    input logic [1:0] err_o,
    input logic       scl_oe_o,
    input logic       eng_en_o,
    input logic       eng_load_o,
    input logic       eng_start_o,
    input logic       eng_stop_o
);

    int unsigned low_run;
    int unsigned pulse_cnt;
    logic        oe_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run   <= 0;
            pulse_cnt <= 0;
            oe_prev   <= 1'b0;
        end else begin
            oe_prev <= scl_oe_o;
            low_run <= scl_oe_o ? low_run + 1 : 0;
            if (!busy_o) begin
                pulse_cnt <= 0;
            end else if (scl_oe_o && !oe_prev) begin
                pulse_cnt <= pulse_cnt + 1;
            end
        end
    end

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    assert_start_in_report_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> !busy_o);

    assert_err_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(err_o));

    assert_engine_off_only_in_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_en_o |-> (busy_o && !done_o));

    assert_scl_only_line_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe_o |-> (busy_o && !eng_en_o));

    assert_low_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe_o |-> (low_run < HALF_CYCLES));

    assert_pulse_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (pulse_cnt <= MAX_PULSES));

    assert_strobes_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eng_load_o, eng_start_o, eng_stop_o}));

    assert_strobes_byte_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_load_o || eng_start_o || eng_stop_o) |-> (busy_o && eng_en_o));

endmodule

bind i2c_bus_recovery i2c_bus_recovery_chk #(
    .HALF_CYCLES (HALF_CYCLES),
    .MAX_PULSES  (MAX_PULSES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .scl_oe_o    (scl_oe_o),
    .eng_en_o    (eng_en_o),
    .eng_load_o  (eng_load_o),
    .eng_start_o (eng_start_o),
    .eng_stop_o  (eng_stop_o)
);

// File: tb/test_i2c_bus_recovery.sv
`timescale 1ns/1ps
module test_i2c_bus_recovery;

    localparam int HALF  = 5;
    localparam int MAXP  = 9;
    localparam int NOJAM = 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       byte_mode_i = 1'b0;
    logic       busy_o, done_o, scl_oe_o, eng_en_o;
    logic [1:0] err_o;
    logic       scl_i, sda_i;
    logic       eng_load_o, eng_start_o, eng_nack_o, eng_stop_o;
    logic [7:0] eng_data_o;
    logic       eng_done_i = 1'b0;

    int checks = 0;
    int fails  = 0;

    // target model
    int hold_k    = 0;
    int jam_after = NOJAM;
    int rel_cnt   = 0;
    logic oe_d = 1'b0;
    logic [3:0] eng_dly = '0;

    always #2 clk = ~clk;

    assign scl_i = !scl_oe_o && !(rel_cnt >= jam_after);
    assign sda_i = !(rel_cnt < hold_k);

    i2c_bus_recovery #(
        .CLK_FREQ_HZ (1_000_000),
        .SCL_FREQ_HZ (100_000),
        .MAX_PULSES  (MAXP)
    ) i_i2c_bus_recovery (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .byte_mode_i (byte_mode_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .err_o       (err_o),
        .scl_i       (scl_i),
        .sda_i       (sda_i),
        .scl_oe_o    (scl_oe_o),
        .eng_en_o    (eng_en_o),
        .eng_load_o  (eng_load_o),
        .eng_data_o  (eng_data_o),
        .eng_start_o (eng_start_o),
        .eng_nack_o  (eng_nack_o),
        .eng_stop_o  (eng_stop_o),
        .eng_done_i  (eng_done_i)
    );

    // count controller releases of SCL, and model a byte engine
    always @(posedge clk) begin
        oe_d <= scl_oe_o;
        if (!busy_o) rel_cnt <= 0;
        else if (oe_d && !scl_oe_o) rel_cnt <= rel_cnt + 1;
        if (eng_start_o || eng_stop_o) eng_dly <= 4'd4;
        else if (eng_dly != 0) eng_dly <= eng_dly - 1'b1;
        eng_done_i <= (eng_dly == 4'd1);
    end

    // monitor, cleared at the start of each run
    int pulses, width_bad, en_lo, busy_cyc, dones, run_len;
    int n_load, n_start, n_stop, n_edone, order_bad, start_nack;
    logic [7:0] load_data;
    logic busy_prev = 1'b0, oe_prev = 1'b0;

    always @(negedge clk) begin
        if (busy_o && !busy_prev) begin
            pulses = 0; width_bad = 0; en_lo = 0; busy_cyc = 0; dones = 0;
            run_len = 0; oe_prev = 1'b0; n_load = 0; n_start = 0; n_stop = 0;
            n_edone = 0; order_bad = 0; start_nack = 0; load_data = 8'h00;
        end
        if (busy_o) begin
            busy_cyc++;
            if (!eng_en_o) en_lo++;
            if (scl_oe_o != oe_prev) begin
                if (run_len != HALF) width_bad++;
                if (scl_oe_o) pulses++;
                run_len = 1;
            end else begin
                run_len++;
            end
            oe_prev = scl_oe_o;
            if (done_o) dones++;
            if (eng_load_o) begin n_load++; load_data = eng_data_o; end
            if (eng_start_o) begin
                n_start++; start_nack = int'(eng_nack_o);
                if (n_load != 1) order_bad++;
            end
            if (eng_done_i) n_edone++;
            if (eng_stop_o) begin
                n_stop++;
                if (n_edone != 1) order_bad++;
            end
        end
        busy_prev = busy_o;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_done();
        while (!done_o) @(negedge clk);
    endtask

    task automatic run_line(input int k, input int j, input bit poke);
        int mp, exp_p, exp_e, exp_busy;
        hold_k = k; jam_after = j;
        @(negedge clk); start_i = 1'b1; byte_mode_i = 1'b0;
        @(negedge clk); start_i = 1'b0;
        chk(busy_o == 1'b1, "R9 busy after start", int'(busy_o), 1);
        chk(err_o == 2'd0, "R10 err cleared at start", int'(err_o), 0);
        if (poke) begin
            repeat (12) @(negedge clk);
            start_i = 1'b1; byte_mode_i = 1'b1;
            @(negedge clk); start_i = 1'b0; byte_mode_i = 1'b0;
        end
        wait_done();
        mp = (j < k) ? j : k;
        if (mp <= MAXP - 1) begin
            exp_p = mp;
            exp_e = (j <= k) ? 1 : 0;
        end else begin
            exp_p = MAXP;
            exp_e = (k <= MAXP) ? 0 : 2;
        end
        chk(err_o == 2'(exp_e), "R4 R5 R6 result code", int'(err_o), exp_e);
        @(negedge clk);
        chk(pulses == exp_p, "R4 R5 R6 pulse count", pulses, exp_p);
        chk(width_bad == 0, "R3 phase widths", width_bad, 0);
        exp_busy = 2 * HALF * exp_p + HALF + 1;
        chk(busy_cyc == exp_busy, "R2 R9 run length", busy_cyc, exp_busy);
        chk(en_lo == busy_cyc - 1, "R2 engine disabled", en_lo, busy_cyc - 1);
        chk(dones == 1, "R9 single done", dones, 1);
        chk(!busy_o && eng_en_o, "R7 engine re-enabled", int'(eng_en_o), 1);
        chk(n_load + n_start + n_stop == 0, "R11 no engine strobes", n_load + n_start + n_stop, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy_o == 0 && done_o == 0 && scl_oe_o == 0, "R1 reset outputs", int'(busy_o), 0);
        chk(err_o == 0 && eng_en_o == 1, "R1 reset err/enable", int'(err_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 R5: sweep of SDA hold lengths, no jam
        for (int k = 0; k <= MAXP + 1; k++) run_line(k, NOJAM, 1'b0);
        // R6: SCL jammed after j releases, SDA held long
        for (int j = 0; j <= MAXP; j++) run_line(20, j, 1'b0);
        // R6 priority irrelevant when SDA frees first
        run_line(4, 6, 1'b0);

        // R10: SDA-stuck code persists while idle
        run_line(MAXP + 1, NOJAM, 1'b0);
        repeat (40) @(negedge clk);
        chk(err_o == 2'd2, "R10 err holds", int'(err_o), 2);
        chk(done_o == 1'b0, "R9 no stray done", int'(done_o), 0);

        // R11: start while busy ignored
        run_line(3, NOJAM, 1'b1);

        // R11: start during report cycle ignored
        hold_k = 0; jam_after = NOJAM;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        wait_done();
        start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(busy_o == 1'b0, "R11 report-cycle start", int'(busy_o), 0);

        // R8: byte mode
        for (int r = 0; r < 2; r++) begin
            hold_k = 20; jam_after = NOJAM;
            @(negedge clk); start_i = 1'b1; byte_mode_i = 1'b1;
            @(negedge clk); start_i = 1'b0; byte_mode_i = 1'b0;
            wait_done();
            chk(err_o == 2'd0, "R8 byte result", int'(err_o), 0);
            @(negedge clk);
            chk(n_load == 1 && load_data == 8'hFF, "R8 load 0xFF", int'(load_data), 255);
            chk(n_start == 1 && start_nack == 1, "R8 start with nack", start_nack, 1);
            chk(n_stop == 1 && n_edone == 2, "R8 stop after done", n_edone, 2);
            chk(order_bad == 0, "R8 order", order_bad, 0);
            chk(pulses == 0 && en_lo == 0, "R8 no line drive", pulses + en_lo, 0);
            chk(dones == 1, "R9 byte single done", dones, 1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule